// File: doc/BRIEF.md
# Link initialization handshake sequencer

This block is a hardware master for the power-up handshake between a chip and its management controller. It talks through an indirect 32-bit register port. Each access is a request held until the transport acknowledges it. On a start pulse the sequencer reads the controller's firmware version and decides whether a handshake is needed. If one is needed, it posts an initialization request that carries one error-correction code, copied to every link. It then polls a completion bit at a fixed interval until the bit is seen or a total timeout runs out.

Afterwards it reads the two retimer mode-status words, holds them on its outputs, and reports one of four outcomes. It also reports whether the shared serial bus may be handed to the host, and whether error-correction mode selection applies to the links that came up. The register transport behind the request/acknowledge port belongs to the surrounding system.

Top module: `lih_seq`

## Requirements
- R1: After reset, `busy_o`, `result_o`, `bus_release_o`, `fec_supported_o` and `reg_req_o` are all 0. No register request is made while the sequencer is idle.
- R2: If the version word read from address 0x1004 is all zeros, the run ends after that single access. The outcome is "uninitialized" (result bit 3), `bus_release_o` is 1, and both status outputs read 0.
- R3: When the version major field (bits [31:28]) is at least 3 and the init word read from 0x1000 has bits [1:0] clear, exactly one write to 0x1000 is made. It carries bit 1 (start) set, bits [23:8] filled with eight copies of the 2-bit `fec_code_i` value (0 none, 1 KR, 2 RS), and every other bit zero.
- R4: When major is at least 3 and the init word already has bit 0 (done) or bit 1 (start) set, no write is made and polling begins directly.
- R5: When the version is nonzero with major below 3, no write to 0x1000 is made; the sequencer goes straight to polling bit 0 of 0x1000.
- R6: After a poll read returns done clear, the next read of 0x1000 is requested no sooner than INTERVAL_CYC cycles after that acknowledge.
- R7: If done is not seen before the TIMEOUT_CYC window expires, the outcome is "timeout" (result bit 1) and `bus_release_o` is 0. Both status words at 0x1020 and 0x1024 are still read and their low 16 bits held on `status_a_o` and `status_b_o`.
- R8: If done is seen and both status words have group code bits [15:8] equal to 0, the outcome is "ok" (result bit 0) and `bus_release_o` is 1.
- R9: If done is seen but either group code is nonzero, the outcome is "retimer error" (result bit 2) and `bus_release_o` stays 1.
- R10: `fec_supported_o` is 1 only when major is at least 3 and at least one status word has a mode identifier (bits [7:0]) other than 0 (reset) or 1 (four 10G links).
- R11: `result_o` is one-hot with at most one bit set. It is cleared and `busy_o` goes high on the start pulse, and it is valid once `busy_o` falls.
- R12: While a request is outstanding without acknowledge, `reg_req_o`, `reg_wr_o`, `reg_addr_o` and `reg_wdata_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go_i | input | 1 | Start pulse, accepted while idle |
| fec_code_i | input | 2 | Error-correction code requested for every link |
| reg_req_o | output | 1 | Register access request, held until acknowledged |
| reg_wr_o | output | 1 | 1 for write, 0 for read |
| reg_addr_o | output | ADDR_W | Internal register address |
| reg_wdata_o | output | 32 | Write data |
| reg_ack_i | input | 1 | One-cycle acknowledge, read data valid with it |
| reg_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Sequence in progress |
| result_o | output | 4 | One-hot outcome: ok, timeout, retimer error, uninitialized |
| bus_release_o | output | 1 | Shared serial bus may be given to the host |
| fec_supported_o | output | 1 | Mode selection applies to the links found |
| status_a_o | output | 16 | Held retimer A status word |
| status_b_o | output | 16 | Held retimer B status word |

## Verification
The bench builds the sequencer with INTERVAL_CYC = 8 and TIMEOUT_CYC = 60 in place of the nominal hundred-millisecond and ten-second values. With these settings, a run that never sees done expires after a handful of polls, and the poll spacing can be measured cycle by cycle. Directed runs cover each version gate, each preset init bit and each outcome. Randomized runs mix firmware majors, poll counts before done, status groups and mode identifiers, and compare against expectations the bench derives from the requirements.

// File: rtl/lih_pkg.sv
package lih_pkg;

  localparam int unsigned DW = 32;
  localparam int unsigned SW = 16;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_VER, S_RD_INIT, S_WR_INIT, S_POLL, S_WAIT, S_RD_STA, S_RD_STB
  } state_t;

  localparam int unsigned RES_OK     = 0;
  localparam int unsigned RES_TMO    = 1;
  localparam int unsigned RES_RTERR  = 2;
  localparam int unsigned RES_UNINIT = 3;

  localparam logic [1:0] FEC_NONE = 2'd0;
  localparam logic [1:0] FEC_KR   = 2'd1;
  localparam logic [1:0] FEC_RS   = 2'd2;

endpackage

// File: rtl/lih_timer.sv
module lih_timer #(
  parameter int unsigned INTERVAL_CYC = 12_500_000,
  parameter int unsigned TIMEOUT_CYC  = 1_250_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic window_on,
  input  logic wait_on,
  output logic wait_done,
  output logic expired
);
  localparam int unsigned IW = $clog2(INTERVAL_CYC + 1);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [IW-1:0] IV_LAST = IW'(INTERVAL_CYC - 1);
  localparam logic [TW-1:0] TO_END  = TW'(TIMEOUT_CYC);

  logic [IW-1:0] iv_cnt;
  logic [TW-1:0] to_cnt;

  always_ff @(posedge clk) begin
    if (rst || !wait_on) iv_cnt <= '0;
    else if (iv_cnt != IV_LAST) iv_cnt <= iv_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !window_on) to_cnt <= '0;
    else if (to_cnt != TO_END) to_cnt <= to_cnt + 1'b1;
  end

  assign wait_done = wait_on && (iv_cnt == IV_LAST);
  assign expired   = (to_cnt == TO_END);

  // R7: once the window has run out it stays expired until the window closes
  p_expire_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (window_on && expired) |=> (expired || !window_on));

endmodule

// File: rtl/lih_status_decode.sv
module lih_status_decode
  import lih_pkg::*;
#(
  parameter int unsigned MIN_MAJOR = 3
) (
  input  logic [SW-1:0] stat_a,
  input  logic [SW-1:0] stat_b,
  input  logic          done_seen,
  input  logic [3:0]    major,
  output logic [3:0]    res,
  output logic          release_bus,
  output logic          fec_ok
);
  logic [1:0] grp_ok;
  logic [1:0] fast_link;

  for (genvar g = 0; g < 2; g++) begin : g_ret
    logic [SW-1:0] w;
    assign w            = (g == 0) ? stat_a : stat_b;
    assign grp_ok[g]    = (w[15:8] == 8'h00);
    assign fast_link[g] = (w[7:0] > 8'd1);
  end

  always_comb begin
    res = '0;
    if (!done_seen)     res[RES_TMO]   = 1'b1;
    else if (&grp_ok)   res[RES_OK]    = 1'b1;
    else                res[RES_RTERR] = 1'b1;
  end

  assign release_bus = done_seen;
  assign fec_ok      = (major >= 4'(MIN_MAJOR)) && (|fast_link);

endmodule

// File: rtl/lih_seq.sv
module lih_seq
  import lih_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned LINKS        = 8,
  parameter int unsigned MIN_MAJOR    = 3,
  parameter int unsigned INTERVAL_CYC = 12_500_000,
  parameter int unsigned TIMEOUT_CYC  = 1_250_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [1:0]        fec_code_i,
  output logic              reg_req_o,
  output logic              reg_wr_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DW-1:0]     reg_wdata_o,
  input  logic              reg_ack_i,
  input  logic [DW-1:0]     reg_rdata_i,
  output logic              busy_o,
  output logic [3:0]        result_o,
  output logic              bus_release_o,
  output logic              fec_supported_o,
  output logic [SW-1:0]     status_a_o,
  output logic [SW-1:0]     status_b_o
);
  localparam logic [ADDR_W-1:0] A_INIT = ADDR_W'(16'h1000);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(16'h1004);
  localparam logic [ADDR_W-1:0] A_STA  = ADDR_W'(16'h1020);
  localparam logic [ADDR_W-1:0] A_STB  = ADDR_W'(16'h1024);
  localparam int unsigned FLD_LO = 8;

  state_t     state;
  logic [3:0] major_q;
  logic       done_seen_q;
  logic [1:0] fec_q;
  logic       wait_done, expired;
  logic [3:0] dec_res;
  logic       dec_rel, dec_fec;
  logic [DW-1:0] start_word;

  always_comb begin
    start_word    = '0;
    start_word[1] = 1'b1;
    for (int i = 0; i < int'(LINKS); i++)
      start_word[FLD_LO + 2*i +: 2] = fec_q;
  end

  lih_timer #(.INTERVAL_CYC(INTERVAL_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst(rst),
    .window_on(state == S_POLL || state == S_WAIT),
    .wait_on(state == S_WAIT),
    .wait_done(wait_done), .expired(expired)
  );

  lih_status_decode #(.MIN_MAJOR(MIN_MAJOR)) u_dec (
    .stat_a(status_a_o), .stat_b(reg_rdata_i[SW-1:0]),
    .done_seen(done_seen_q), .major(major_q),
    .res(dec_res), .release_bus(dec_rel), .fec_ok(dec_fec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;  major_q <= '0;  done_seen_q <= 1'b0;  fec_q <= '0;
      reg_req_o <= 1'b0;  reg_wr_o <= 1'b0;  reg_addr_o <= '0;  reg_wdata_o <= '0;
      busy_o <= 1'b0;  result_o <= '0;  bus_release_o <= 1'b0;
      fec_supported_o <= 1'b0;  status_a_o <= '0;  status_b_o <= '0;
    end else begin
      case (state)
        S_IDLE: if (go_i) begin
          busy_o <= 1'b1;  result_o <= '0;  bus_release_o <= 1'b0;
          fec_supported_o <= 1'b0;  status_a_o <= '0;  status_b_o <= '0;
          done_seen_q <= 1'b0;  fec_q <= fec_code_i;
          reg_req_o <= 1'b1;  reg_wr_o <= 1'b0;  reg_addr_o <= A_VER;
          state <= S_RD_VER;
        end
        S_RD_VER: if (reg_ack_i) begin
          major_q <= reg_rdata_i[31:28];
          if (reg_rdata_i == '0) begin
            reg_req_o <= 1'b0;  busy_o <= 1'b0;
            result_o[RES_UNINIT] <= 1'b1;  bus_release_o <= 1'b1;
            state <= S_IDLE;
          end else begin
            reg_addr_o <= A_INIT;
            state <= (reg_rdata_i[31:28] >= 4'(MIN_MAJOR)) ? S_RD_INIT : S_POLL;
          end
        end
        S_RD_INIT: if (reg_ack_i) begin
          if (reg_rdata_i[1:0] != 2'b00) state <= S_POLL;
          else begin
            reg_wr_o <= 1'b1;  reg_wdata_o <= start_word;  state <= S_WR_INIT;
          end
        end
        S_WR_INIT: if (reg_ack_i) begin
          reg_wr_o <= 1'b0;  state <= S_POLL;
        end
        S_POLL: if (reg_ack_i) begin
          if (reg_rdata_i[0]) begin
            done_seen_q <= 1'b1;  reg_addr_o <= A_STA;  state <= S_RD_STA;
          end else if (expired) begin
            reg_addr_o <= A_STA;  state <= S_RD_STA;
          end else begin
            reg_req_o <= 1'b0;  state <= S_WAIT;
          end
        end
        S_WAIT: if (wait_done) begin
          reg_req_o <= 1'b1;  reg_addr_o <= A_INIT;  state <= S_POLL;
        end
        S_RD_STA: if (reg_ack_i) begin
          status_a_o <= reg_rdata_i[SW-1:0];  reg_addr_o <= A_STB;  state <= S_RD_STB;
        end
        S_RD_STB: if (reg_ack_i) begin
          status_b_o <= reg_rdata_i[SW-1:0];  reg_req_o <= 1'b0;  busy_o <= 1'b0;
          result_o <= dec_res;  bus_release_o <= dec_rel;  fec_supported_o <= dec_fec;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (reg_req_o && !reg_ack_i) |=> (reg_req_o && $stable(reg_addr_o) &&
                                   $stable(reg_wr_o) && $stable(reg_wdata_o)));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !reg_req_o);
  p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(result_o));
  p_busy_clear_r11: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (result_o == 4'b0000));
  p_timeout_hold_r7: assert property (@(posedge clk) disable iff (rst)
    result_o[RES_TMO] |-> !bus_release_o);
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    (result_o[RES_OK] || result_o[RES_RTERR] || result_o[RES_UNINIT]) |-> bus_release_o);

endmodule

// File: tb/sim_lih_seq.sv
module sim_lih_seq;
  localparam int INTERVAL = 8;
  localparam int TIMEOUT  = 60;
  localparam int NEVER    = -1;

  logic clk = 1'b0, rst = 1'b1, go = 1'b0;
  logic [1:0]  fec = 2'd2;
  logic        reg_req, reg_wr, reg_ack = 1'b0;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata = '0;
  logic        busy, bus_rel, fec_sup;
  logic [3:0]  result;
  logic [15:0] sta_o, stb_o;

  always #4 clk = ~clk;

  lih_seq #(.INTERVAL_CYC(INTERVAL), .TIMEOUT_CYC(TIMEOUT)) u0 (
    .clk(clk), .rst(rst), .go_i(go), .fec_code_i(fec),
    .reg_req_o(reg_req), .reg_wr_o(reg_wr), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_ack_i(reg_ack), .reg_rdata_i(reg_rdata),
    .busy_o(busy), .result_o(result), .bus_release_o(bus_rel),
    .fec_supported_o(fec_sup), .status_a_o(sta_o), .status_b_o(stb_o));

  int nchk = 0, nfail = 0, cyc = 0;
  // responder model state
  logic [31:0] m_ver, m_init, m_sta, m_stb, last_wdata;
  int m_done_after, n_init_rd, n_wr, n_acc, lat, req_start, gap_ack;
  bit in_req, gap_armed, major_hi;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (reg_req && !in_req && !reg_ack) begin in_req = 1; req_start = cyc; end
      if (reg_ack) begin
        reg_ack = 1'b0;
        lat = int'($urandom % 3);
      end else if (reg_req && in_req) begin
        if (lat > 0) lat--;
        else begin
          reg_ack = 1'b1;  in_req = 0;  n_acc++;
          if (reg_wr) begin
            n_wr++;  last_wdata = reg_wdata;  m_init = reg_wdata;  gap_armed = 0;
          end else if (reg_addr == 16'h1000) begin
            reg_rdata = m_init | {31'd0, (m_done_after != NEVER && n_init_rd >= m_done_after)};
            if (gap_armed)  // R6
              check(req_start - gap_ack >= INTERVAL, "R6 poll spacing",
                    32'(req_start - gap_ack), INTERVAL);
            gap_armed = !reg_rdata[0] && !(n_init_rd == 0 && major_hi);
            gap_ack = cyc;
            n_init_rd++;
          end else begin
            gap_armed = 0;
            case (reg_addr)
              16'h1004: reg_rdata = m_ver;
              16'h1020: reg_rdata = m_sta;
              16'h1024: reg_rdata = m_stb;
              default:  reg_rdata = 32'hdead_beef;
            endcase
          end
        end
      end
    end
  end

  function automatic logic [31:0] exp_start(input logic [1:0] c);
    logic [31:0] w = 32'h2;
    for (int i = 0; i < 8; i++) w[8 + 2*i +: 2] = c;
    return w;
  endfunction

  task automatic run(input logic [31:0] ver, input logic [31:0] preset, input int done_after,
                     input logic [31:0] sa, input logic [31:0] sb, input logic [1:0] code);
    bit hi, zero, done, grp_ok, fast;
    logic [3:0] er;
    m_ver = ver;  m_init = preset;  m_done_after = done_after;  m_sta = sa;  m_stb = sb;
    n_init_rd = 0;  n_wr = 0;  n_acc = 0;  gap_armed = 0;  last_wdata = '0;
    zero = (ver == 0);  hi = (ver[31:28] >= 4'd3);  major_hi = hi;
    done = preset[0] || (done_after != NEVER);
    grp_ok = (sa[15:8] == 0) && (sb[15:8] == 0);
    fast = (sa[7:0] > 1) || (sb[7:0] > 1);
    @(negedge clk); go = 1'b1; fec = code;
    @(negedge clk); go = 1'b0;
    check(busy && result == 4'b0, "R11 busy on start", {27'd0, busy, result}, 32'h10);
    while (busy) @(negedge clk);
    check($onehot(result), "R11 one-hot", {28'd0, result}, 32'd1);
    if (zero) begin
      check(result == 4'b1000, "R2 uninit result", {28'd0, result}, 32'h8);
      check(bus_rel == 1'b1, "R2 bus release", {31'd0, bus_rel}, 1);
      check(n_acc == 1, "R2 single access", n_acc, 1);
      check(sta_o == 0 && stb_o == 0 && !fec_sup, "R2 status cleared", {sta_o, stb_o}, 0);
    end else begin
      er = !done ? 4'b0010 : (grp_ok ? 4'b0001 : 4'b0100);
      if (!done)  check(result == er, "R7 timeout result", {28'd0, result}, {28'd0, er});
      else if (grp_ok) check(result == er, "R8 ok result", {28'd0, result}, {28'd0, er});
      else        check(result == er, "R9 retimer error result", {28'd0, result}, {28'd0, er});
      check(bus_rel == done, done ? "R8 R9 bus release" : "R7 bus withheld",
            {31'd0, bus_rel}, {31'd0, done});
      check(sta_o == sa[15:0] && stb_o == sb[15:0], "R7 status words held",
            {sta_o, stb_o}, {sa[15:0], sb[15:0]});
      check(fec_sup == (hi && fast), "R10 fec supported", {31'd0, fec_sup}, {31'd0, hi && fast});
      if (hi && preset[1:0] == 0) begin
        check(n_wr == 1, "R3 one start write", n_wr, 1);
        check(last_wdata == exp_start(code), "R3 start word", last_wdata, exp_start(code));
      end else if (hi) check(n_wr == 0, "R4 no write when preset", n_wr, 0);
      else             check(n_wr == 0, "R5 no write for old major", n_wr, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    lat = 0;  in_req = 0;  m_done_after = NEVER;  major_hi = 0;
    repeat (3) @(negedge clk);
    check(!busy && result == 0 && !bus_rel && !fec_sup && !reg_req, "R1 reset state",
          {26'd0, busy, bus_rel, fec_sup, reg_req, 2'b0}, 0);
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    check(!reg_req, "R1 idle quiet", {31'd0, reg_req}, 0);
    // directed corners
    run(32'h0, 32'h0, 1, 32'h0002, 32'h0002, 2'd2);            // version zero
    run(32'h2010_0000, 32'h1, NEVER, 32'h0002, 32'h0003, 2'd2); // old major, done preset
    run(32'h2000_0000, 32'h0, 2, 32'h0001, 32'h0000, 2'd2);     // old major, polls
    run(32'h3000_0000, 32'h0, 1, 32'h0002, 32'h0002, 2'd2);     // RS write
    run(32'h3100_0000, 32'h0, 3, 32'h0005, 32'h0001, 2'd1);     // KR write
    run(32'h4000_0000, 32'h0, 1, 32'h0000, 32'h0001, 2'd0);     // none, fec unsupported
    run(32'h3000_0000, 32'h2, 2, 32'h0004, 32'h0002, 2'd2);     // start preset
    run(32'h3000_0000, 32'h0, NEVER, 32'h0102, 32'h0002, 2'd2); // timeout
    run(32'h3000_0000, 32'h0, 1, 32'h0302, 32'h0002, 2'd2);     // group error A
    run(32'h3000_0000, 32'h3, 1, 32'h0002, 32'hFF01, 2'd2);     // group error B
    for (int t = 0; t < 40; t++) begin
      logic [31:0] v, p, a, b;
      int d;
      v = {4'($urandom % 6), 8'($urandom), 4'(1 + $urandom % 15), 16'($urandom)};
      if ($urandom % 8 == 0) v = 0;
      p = {30'd0, 2'($urandom)};
      d = ($urandom % 5 == 0) ? NEVER : int'(1 + $urandom % 3);
      a = {16'd0, ($urandom % 4 == 0) ? 8'($urandom) : 8'h00, 8'($urandom % 6)};
      b = {16'd0, ($urandom % 4 == 0) ? 8'($urandom) : 8'h00, 8'($urandom % 6)};
      run(v, p, d, a, b, 2'($urandom % 3));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule